// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit with Sticky Status

This block is the integer arithmetic slice of a small processor's execute stage. It takes two signed operands and an operation code. On a clock edge where the valid strobe is high, it registers one result word. It offers five operations:

- add that wraps on overflow
- subtract that wraps on overflow
- add that saturates at the signed limits
- subtract that saturates at the signed limits
- signed multiply that keeps only the low word of the product

Each operation also updates four status bits. Overflow reports whether the last result left the signed range. Advanced overflow reports whether the two top bits of the result differ, which is a cheap early warning of growth. Each of these two flags has a sticky twin that accumulates across operations. The sticky flags are cleared only by reset or by a dedicated synchronous clear input, so software can run a whole loop and test once at the end whether anything overflowed.

Top module: `sat_alu`

## Requirements
- R1: After a synchronous active-low reset, the result is zero and all four flags are zero.
- R2: Operation code 0 is a wrapping add. The result is the low word of a+b. Overflow is 1 exactly when both operands have the same sign and the result's sign differs from it.
- R3: Operation code 1 is a wrapping subtract. The result is the low word of a-b. Overflow is 1 exactly when the operand signs differ and the result's sign differs from the sign of a.
- R4: Operation codes 2 (add) and 3 (subtract) saturate. The exact result is computed, then clamped to 0x7FFFFFFF above the positive limit and to 0x80000000 below the negative limit.
- R5: For the saturating codes, overflow is 1 when clamping happened and 0 otherwise.
- R6: Operation code 4 returns the low 32 bits of the signed 64-bit product. Overflow is 1 when the high word differs from the sign extension of bit 31 of the low word.
- R7: Advanced overflow is bit 31 XOR bit 30 of the written value. For the saturating codes it is taken from the exact result before clamping.
- R8: Sticky overflow ORs in each new overflow value, and sticky advanced overflow ORs in each new advanced-overflow value. Neither ever drops on its own.
- R9: A high flag-clear input zeroes both sticky flags at the next edge. If valid is also high, the sticky flags take only the new operation's values.
- R10: While valid is low, or for operation codes 5 to 7, the result, overflow and advanced overflow hold their values. The sticky flags then change only through flag-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Perform the operation at this edge |
| op_i | input | 3 | Operation code (see R2 to R6, R10) |
| a_i | input | 32 | First signed operand |
| b_i | input | 32 | Second signed operand |
| flag_clr_i | input | 1 | Clears both sticky flags |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Overflow of the last operation |
| sovf_o | output | 1 | Sticky overflow |
| aovf_o | output | 1 | Advanced overflow of the last operation |
| saovf_o | output | 1 | Sticky advanced overflow |

## Verification
The bound checker watches five properties on every cycle:

- outputs stay frozen while nothing is requested;
- a rising flag is always mirrored in its sticky twin;
- sticky flags drop only under clear;
- clear with no operation empties both sticky flags;
- a saturating overflow always leaves a limit value in the result.

Some behaviour is beyond a cycle-local property. This covers the exact wrapped and clamped values, the multiply overflow test against the high word, and the choice of the unclamped value for advanced overflow. The directed scenarios show these. For example, the negative-limit case -2^31 + -2^31 must give advanced overflow 0, although the clamped word 0x80000000 would give 1.

// File: rtl/sat_alu_pkg.sv
// Package: shared operation codes for the saturating arithmetic unit.
// Assumes op codes above ALU_MUL are treated as no-operation by the top.
package sat_alu_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_ADDS = 3'd2,
        ALU_SUBS = 3'd3,
        ALU_MUL  = 3'd4
    } alu_op_e;
endpackage

// File: rtl/sat_alu_addsub.sv
// Module: combinational add/subtract with one guard bit.
// Produces the wrapped word, the clamped word, the wrap overflow per sign
// rule, the clamp indication and the advanced overflow of the exact value.
// Assumes W >= 2.
module sat_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] wrap_res,
    output logic [W-1:0] sat_res,
    output logic         wrap_ov,
    output logic         sat_hit,
    output logic         wide_aov
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [W:0] wide;

    // exact sum or difference on W+1 bits, sign extended operands
    always_comb begin
        if (sub) wide = {a[W-1], a} - {b[W-1], b};
        else     wide = {a[W-1], a} + {b[W-1], b};
    end

    // wrap result, sign-rule overflow and clamping
    always_comb begin
        wrap_res = wide[W-1:0];
        if (sub) wrap_ov = (a[W-1] != b[W-1]) && (wrap_res[W-1] != a[W-1]);
        else     wrap_ov = (a[W-1] == b[W-1]) && (wrap_res[W-1] != a[W-1]);
        sat_hit  = wide[W] != wide[W-1];
        if (!sat_hit)     sat_res = wrap_res;
        else if (wide[W]) sat_res = NEG_LIM;
        else              sat_res = POS_LIM;
        wide_aov = wide[W-1] ^ wide[W-2];
    end
endmodule

// File: rtl/sat_alu_mul.sv
// Module: signed W x W multiply keeping the low word.
// Flags overflow when the high word is not the sign extension of the low.
module sat_alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic         ov
);
    logic signed [2*W-1:0] prod;

    // full product, low word and range test
    always_comb begin
        prod = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        lo   = prod[W-1:0];
        ov   = prod[2*W-1:W] != {W{prod[W-1]}};
    end
endmodule

// File: rtl/sat_alu_flags.sv
// Module: status flag registers.
// Last-operation flags load on upd; sticky flags OR in new values on upd
// and are zeroed by clr (clr applied before the OR). Synchronous reset.
module sat_alu_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic clr,
    input  logic ov_n,
    input  logic aov_n,
    output logic ov,
    output logic sov,
    output logic aov,
    output logic saov
);
    logic sov_base, saov_base;

    // sticky base after optional clear
    always_comb begin
        sov_base  = clr ? 1'b0 : sov;
        saov_base = clr ? 1'b0 : saov;
    end

    // flag state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov   <= 1'b0;
            sov  <= 1'b0;
            aov  <= 1'b0;
            saov <= 1'b0;
        end else begin
            if (upd) begin
                ov   <= ov_n;
                aov  <= aov_n;
                sov  <= sov_base | ov_n;
                saov <= saov_base | aov_n;
            end else begin
                sov  <= sov_base;
                saov <= saov_base;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
// Module: saturating signed arithmetic unit with sticky status (top).
// Registers one result and its flags per valid cycle; unknown op codes
// and idle cycles leave result and last-operation flags unchanged.
// Synchronous active-low reset.
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            flag_clr_i,
    output logic [W-1:0]    result_o,
    output logic            ovf_o,
    output logic            sovf_o,
    output logic            aovf_o,
    output logic            saovf_o
);
    logic [W-1:0] as_wrap, as_sat, mul_lo, res_n;
    logic         as_ov, as_hit, as_aov, mul_ov;
    logic         is_sub, upd, ov_n, aov_n;

    // subtract select for the shared adder
    always_comb is_sub = (op_i == ALU_SUB) || (op_i == ALU_SUBS);

    sat_alu_addsub #(.W(W)) u_addsub (
        .a(a_i), .b(b_i), .sub(is_sub),
        .wrap_res(as_wrap), .sat_res(as_sat), .wrap_ov(as_ov),
        .sat_hit(as_hit), .wide_aov(as_aov)
    );

    sat_alu_mul #(.W(W)) u_mul (
        .a(a_i), .b(b_i), .lo(mul_lo), .ov(mul_ov)
    );

    // operation decode: next result and flag values
    always_comb begin
        upd   = valid_i;
        res_n = result_o;
        ov_n  = 1'b0;
        aov_n = 1'b0;
        case (op_i)
            ALU_ADD, ALU_SUB: begin
                res_n = as_wrap;
                ov_n  = as_ov;
                aov_n = as_wrap[W-1] ^ as_wrap[W-2];
            end
            ALU_ADDS, ALU_SUBS: begin
                res_n = as_sat;
                ov_n  = as_hit;
                aov_n = as_aov;
            end
            ALU_MUL: begin
                res_n = mul_lo;
                ov_n  = mul_ov;
                aov_n = mul_lo[W-1] ^ mul_lo[W-2];
            end
            default: upd = 1'b0;
        endcase
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n)   result_o <= '0;
        else if (upd) result_o <= res_n;
    end

    sat_alu_flags u_flags (
        .clk(clk), .rst_n(rst_n), .upd(upd), .clr(flag_clr_i),
        .ov_n(ov_n), .aov_n(aov_n),
        .ov(ovf_o), .sov(sovf_o), .aov(aovf_o), .saov(saovf_o)
    );
endmodule

// Checker: temporal properties of the arithmetic unit, bound to the top.
module sat_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [2:0]   op_i,
    input logic         flag_clr_i,
    input logic [W-1:0] result_o,
    input logic         ovf_o,
    input logic         sovf_o,
    input logic         aovf_o,
    input logic         saovf_o
);
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !flag_clr_i) |=> ($stable(result_o) && $stable(ovf_o) && $stable(aovf_o) && $stable(sovf_o) && $stable(saovf_o))); // R10
    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 3'd2 || op_i == 3'd3)) |=> (!ovf_o || result_o == POS_LIM || result_o == NEG_LIM)); // R4
    AST_OV_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> sovf_o); // R8
    AST_AOV_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aovf_o) |-> saovf_o); // R8
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr_i && sovf_o && saovf_o) |=> (sovf_o && saovf_o)); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !valid_i) |=> (!sovf_o && !saovf_o)); // R9
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .flag_clr_i(flag_clr_i), .result_o(result_o), .ovf_o(ovf_o),
    .sovf_o(sovf_o), .aovf_o(aovf_o), .saovf_o(saovf_o)
);

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        flag_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        ovf_o, sovf_o, aovf_o, saovf_o;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    sat_alu u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .flag_clr_i(flag_clr_i),
        .result_o(result_o), .ovf_o(ovf_o), .sovf_o(sovf_o),
        .aovf_o(aovf_o), .saovf_o(saovf_o)
    );

    // compare result and flags {ov, sov, aov, saov}
    task automatic expect_out(string req, logic [31:0] res, logic [3:0] fl);
        tests++;
        if (result_o !== res) begin
            fails++;
            $display("FAIL %s result got %h exp %h", req, result_o, res);
        end
        tests++;
        if ({ovf_o, sovf_o, aovf_o, saovf_o} !== fl) begin
            fails++;
            $display("FAIL %s flags got %b exp %b", req,
                     {ovf_o, sovf_o, aovf_o, saovf_o}, fl);
        end
    endtask

    // one clocked step, then outputs sampled at the following falling edge
    task automatic step(logic v, logic [2:0] op, logic [31:0] a, logic [31:0] b, logic clr);
        valid_i = v; op_i = op; a_i = a; b_i = b; flag_clr_i = clr;
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0; flag_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1", 32'h0, 4'b0000);
    endtask

    task automatic t_wrap_add();
        step(1, 3'd0, 32'd5, 32'd7, 0);
        expect_out("R2", 32'd12, 4'b0000);
        step(1, 3'd0, 32'h7FFFFFFF, 32'd1, 0);
        expect_out("R2 R7", 32'h80000000, 4'b1111);
        step(0, 3'd0, 32'h0, 32'h0, 1);
        expect_out("R9", 32'h80000000, 4'b1010);
    endtask

    task automatic t_wrap_sub();
        step(1, 3'd1, 32'd3, 32'd5, 0);
        expect_out("R3", 32'hFFFFFFFE, 4'b0000);
        step(1, 3'd1, 32'h80000000, 32'd1, 0);
        expect_out("R3 R7", 32'h7FFFFFFF, 4'b1111);
        step(0, 3'd1, 32'h0, 32'h0, 1);
        expect_out("R9", 32'h7FFFFFFF, 4'b1010);
    endtask

    task automatic t_sat();
        step(1, 3'd2, 32'h80000000, 32'h80000000, 0);
        expect_out("R4 R7 unclamped", 32'h80000000, 4'b1100);
        step(1, 3'd2, 32'd100, 32'hFFFFFFE2, 0);
        expect_out("R5 R8", 32'd70, 4'b0100);
        step(1, 3'd3, 32'h7FFFFFFF, 32'hFFFFFFFF, 0);
        expect_out("R4 R5", 32'h7FFFFFFF, 4'b1111);
        step(1, 3'd3, 32'h80000000, 32'd1, 0);
        expect_out("R4 R7", 32'h80000000, 4'b1111);
    endtask

    task automatic t_mul();
        step(1, 3'd4, 32'd6, 32'd7, 1);
        expect_out("R6 R9 clear with op", 32'd42, 4'b0000);
        step(1, 3'd4, 32'h00010000, 32'h00010000, 0);
        expect_out("R6", 32'h0, 4'b1100);
        step(1, 3'd4, 32'hFFFFFFFD, 32'd5, 0);
        expect_out("R6 R8", 32'hFFFFFFF1, 4'b0100);
        step(1, 3'd4, 32'h40000000, 32'd1, 0);
        expect_out("R6 R7", 32'h40000000, 4'b0111);
    endtask

    task automatic t_hold();
        step(0, 3'd0, 32'h12345678, 32'h7FFFFFFF, 0);
        expect_out("R10 idle", 32'h40000000, 4'b0111);
        step(1, 3'd5, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);
        expect_out("R10 code5", 32'h40000000, 4'b0111);
        step(1, 3'd7, 32'h80000000, 32'h1, 0);
        expect_out("R10 code7", 32'h40000000, 4'b0111);
        step(1, 3'd1, 32'd9, 32'd9, 0);
        expect_out("R3 R8 equal operands", 32'h0, 4'b0101);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wrap_add();
        t_wrap_sub();
        t_sat();
        t_mul();
        t_hold();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule